// File: doc/BRIEF.md
# Chained Vector Pipeline Timing Sequencer

This block works out, cycle by cycle, when each instruction of a short vector program would start and finish on a small vector unit built from pipelined functional units. The program holds loads, stores, vector-vector multiplies, vector-by-scalar multiplies and adds on vectors of fixed length (64 elements by default). Every unit delivers one element per cycle once its start-up latency has passed. The block does not compute any data. It produces the schedule only: one start cycle and one finish cycle per instruction, and the completion time of the whole program.

Two settings shape the schedule. The first is the chaining switch. When chaining is on, a dependent instruction may start as soon as the first element of its source leaves the producing pipe. When chaining is off, instructions are packed into convoys of independent instructions on distinct units, and a convoy waits until the previous convoy has drained completely. The second setting is the memory-port arrangement: one shared load/store unit, one load unit plus one store unit, or two general load/store units.

Software loads the program as a flat word together with a count, then pulses start. The block evaluates one instruction per clock and raises done with every result held stable until the next start.

Top module: `vchain_seq`

## Requirements
- R1: After reset, busy and done are low, and the total and every start and finish output are zero.
- R2: A start pulse sampled while busy is low latches the program, the count and the settings. Busy rises on that same edge unless the count is zero. The program is evaluated at one instruction per clock, and done rises on the n-th edge after the sampling edge (on the sampling edge itself when n is zero), at which point busy falls. A count above the instruction capacity is treated as the capacity. A start pulse while busy is ignored. Done and the total stay stable until the next start.
- R3: Each vector instruction finishes at its start plus its unit latency plus the vector length. Latencies are 12 cycles for load and store, 7 for both multiplies and 6 for add.
- R4: Instructions issue in program order, so no instruction starts before the instruction ahead of it.
- R5: With chaining on, an instruction that reads a vector register starts no earlier than the producing instruction's start plus that producer's latency. A register that nothing earlier in the program wrote is ready at cycle 0.
- R6: A unit stays occupied from an instruction's start to its finish. The next instruction on that unit starts no earlier than that finish.
- R7: The memory-port setting is coded as follows: 0 means one shared unit for loads and stores; 1 means a dedicated load unit and a dedicated store unit; 2 means two general units, with the one that frees first chosen and unit 0 taking a tie; 3 behaves like 0.
- R8: With chaining off, an instruction joins the current convoy unless it reads a register written inside that convoy or no suitable unit is left in it. In either of those cases it opens a new convoy, which starts at the latest finish of everything issued so far. Every instruction starts at its convoy's start.
- R9: The second register field of a vector-by-scalar multiply names a scalar and has no effect on timing. The source fields of a load have no effect either.
- R10: Opcodes 5 to 7 are no-operations. Each starts and finishes at the start of the instruction ahead of it (0 when it comes first), and it occupies no unit and writes no register.
- R11: The total equals the largest finish over the program, and is 0 for an empty program.
- R12: Instruction i occupies bits [12i+11:12i] of the program word. Within it, bits [11:9] hold the opcode (0 load, 1 store, 2 vector multiply, 3 vector-by-scalar multiply, 4 add), bits [8:6] the destination, bits [5:3] source A (the data source of a store) and bits [2:0] source B.
- R13: With chaining on, load, vector-by-scalar multiply and store on dependent registers take 152 cycles with the shared unit and 95 with separate load and store units. The six-instruction multiply-add program with two general units and chaining off takes 298.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while not busy |
| chain_en_i | input | 1 | Element chaining enable |
| ls_mode_i | input | 2 | Memory-port arrangement code (R7) |
| n_instr_i | input | 4 | Number of instructions in the program |
| prog_i | input | 96 | Packed program, 12 bits per instruction (R12) |
| busy_o | output | 1 | Program evaluation in progress |
| done_o | output | 1 | Schedule complete and outputs valid |
| total_o | output | 12 | Completion cycle of the program |
| start_cyc_o | output | 96 | Start cycle of each instruction, 12 bits each |
| finish_cyc_o | output | 96 | Finish cycle of each instruction, 12 bits each |

## Verification
Each start pulse is given at a falling edge. The bench then counts rising edges until done appears at a falling edge, and it requires that count to equal the clamped instruction count exactly: zero edges beyond the sampling edge for an empty program, n for the others. Start, finish and total values are read only after done, at a falling edge, and are compared with a schedule the bench derives from the requirements. A few fixed totals (152, 95, 298) and hand-derived start cycles are checked directly. Busy is sampled on the falling edge right after the sampling edge, and a second start pulse is injected at that point to show it is ignored.

// File: rtl/vchain_pkg.sv
package vchain_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_MULV  = 3'd2,
    OP_MULVS = 3'd3,
    OP_ADDV  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    LSM_SHARED = 2'd0,
    LSM_SPLIT  = 2'd1,
    LSM_DUAL   = 2'd2,
    LSM_RSVD   = 2'd3
  } ls_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;

  localparam int NSLOT = 4;
  localparam logic [1:0] SLOT_LS0 = 2'd0;
  localparam logic [1:0] SLOT_LS1 = 2'd1;
  localparam logic [1:0] SLOT_MUL = 2'd2;
  localparam logic [1:0] SLOT_ADD = 2'd3;

  function automatic logic op_valid(input logic [2:0] op);
    return op <= OP_ADDV;
  endfunction

  function automatic logic op_is_mem(input logic [2:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  function automatic logic op_is_mul(input logic [2:0] op);
    return (op == OP_MULV) || (op == OP_MULVS);
  endfunction

  // vector source A is read by store, both multiplies and add
  function automatic logic op_reads_a(input logic [2:0] op);
    return (op == OP_STORE) || op_is_mul(op) || (op == OP_ADDV);
  endfunction

  // vector source B is read only by the two-vector operations
  function automatic logic op_reads_b(input logic [2:0] op);
    return (op == OP_MULV) || (op == OP_ADDV);
  endfunction

  function automatic logic op_writes(input logic [2:0] op);
    return (op == OP_LOAD) || op_is_mul(op) || (op == OP_ADDV);
  endfunction

endpackage

// File: rtl/vchain_units.sv
module vchain_units import vchain_pkg::*; #(
  parameter int CYC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             commit,
  input  logic [2:0]       op,
  input  logic [1:0]       ls_mode,
  input  logic [CYC_W-1:0] fin,
  output logic             slot_ok,
  output logic [CYC_W-1:0] slot_free
);

  logic [CYC_W-1:0] free_q [NSLOT];
  logic [1:0]       slot;
  logic [1:0]       mem_pick;

  // pick a memory port for this operation
  always_comb begin
    mem_pick = SLOT_LS0;
    unique case (ls_mode)
      LSM_SPLIT: mem_pick = (op == OP_STORE) ? SLOT_LS1 : SLOT_LS0;
      LSM_DUAL:  mem_pick = (free_q[SLOT_LS1] < free_q[SLOT_LS0]) ? SLOT_LS1 : SLOT_LS0;
      default:   mem_pick = SLOT_LS0;
    endcase
  end

  always_comb begin
    slot    = SLOT_ADD;
    slot_ok = 1'b1;
    if (op_is_mem(op))       slot = mem_pick;
    else if (op_is_mul(op))  slot = SLOT_MUL;
    else if (op == OP_ADDV)  slot = SLOT_ADD;
    else                     slot_ok = 1'b0;
  end

  assign slot_free = free_q[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) free_q[s] <= '0;
    end else if (clr) begin
      for (int s = 0; s < NSLOT; s++) free_q[s] <= '0;
    end else if (commit && slot_ok) begin
      free_q[slot] <= fin;
    end
  end

  // a unit is never handed back earlier than it was already busy
  AST_UNIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    commit && slot_ok |-> fin >= slot_free); // R6

endmodule

// File: rtl/vchain_regs.sv
module vchain_regs #(
  parameter int NREG  = 8,
  parameter int REG_W = 3,
  parameter int CYC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [REG_W-1:0] rd_a,
  input  logic [REG_W-1:0] rd_b,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_addr,
  input  logic [CYC_W-1:0] wr_first,
  input  logic             conv_clear,
  output logic [CYC_W-1:0] first_a,
  output logic [CYC_W-1:0] first_b,
  output logic             inconv_a,
  output logic             inconv_b
);

  logic [CYC_W-1:0] first_q [NREG];
  logic [NREG-1:0]  inconv_q;

  assign first_a  = first_q[rd_a];
  assign first_b  = first_q[rd_b];
  assign inconv_a = inconv_q[rd_a];
  assign inconv_b = inconv_q[rd_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) first_q[r] <= '0;
      inconv_q <= '0;
    end else if (clr) begin
      for (int r = 0; r < NREG; r++) first_q[r] <= '0;
      inconv_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en && wr_addr == REG_W'(r)) first_q[r] <= wr_first;
        inconv_q[r] <= (inconv_q[r] && !conv_clear) || (wr_en && wr_addr == REG_W'(r));
      end
    end
  end

endmodule

// File: rtl/vchain_convoy.sv
module vchain_convoy import vchain_pkg::*; #(
  parameter int CYC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             commit,
  input  logic [2:0]       op,
  input  logic [1:0]       ls_mode,
  input  logic             dep_hit,
  input  logic [CYC_W-1:0] fin,
  output logic             need_new,
  output logic [CYC_W-1:0] base
);

  logic [CYC_W-1:0] cstart_q, cend_q;
  logic [1:0]       ls_cnt_q;
  logic             ld_q, st_q, mul_q, add_q;
  logic             full;

  always_comb begin
    full = 1'b0;
    if (op_is_mem(op)) begin
      unique case (ls_mode)
        LSM_SPLIT: full = (op == OP_LOAD) ? ld_q : st_q;
        LSM_DUAL:  full = (ls_cnt_q >= 2'd2);
        default:   full = (ls_cnt_q != 2'd0);
      endcase
    end else if (op_is_mul(op)) begin
      full = mul_q;
    end else if (op == OP_ADDV) begin
      full = add_q;
    end
  end

  assign need_new = op_valid(op) && (dep_hit || full);
  assign base     = need_new ? cend_q : cstart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cstart_q <= '0; cend_q <= '0; ls_cnt_q <= '0;
      ld_q <= 1'b0; st_q <= 1'b0; mul_q <= 1'b0; add_q <= 1'b0;
    end else if (clr) begin
      cstart_q <= '0; cend_q <= '0; ls_cnt_q <= '0;
      ld_q <= 1'b0; st_q <= 1'b0; mul_q <= 1'b0; add_q <= 1'b0;
    end else if (commit && op_valid(op)) begin
      if (need_new) begin
        cstart_q <= cend_q;
        ls_cnt_q <= 2'(op_is_mem(op));
        ld_q     <= (op == OP_LOAD);
        st_q     <= (op == OP_STORE);
        mul_q    <= op_is_mul(op);
        add_q    <= (op == OP_ADDV);
      end else begin
        ls_cnt_q <= ls_cnt_q + 2'(op_is_mem(op));
        ld_q     <= ld_q  || (op == OP_LOAD);
        st_q     <= st_q  || (op == OP_STORE);
        mul_q    <= mul_q || op_is_mul(op);
        add_q    <= add_q || (op == OP_ADDV);
      end
      if (fin > cend_q) cend_q <= fin;
    end
  end

endmodule

// File: rtl/vchain_seq.sv
module vchain_seq import vchain_pkg::*; #(
  parameter int N_INSTR = 8,
  parameter int N_VREG  = 8,
  parameter int VLEN    = 64,
  parameter int LAT_LS  = 12,
  parameter int LAT_MUL = 7,
  parameter int LAT_ADD = 6,
  parameter int CYC_W   = 12,
  localparam int REG_W   = $clog2(N_VREG),
  localparam int INSTR_W = 3 + 3 * REG_W,
  localparam int CNT_W   = $clog2(N_INSTR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     chain_en_i,
  input  logic [1:0]               ls_mode_i,
  input  logic [CNT_W-1:0]         n_instr_i,
  input  logic [N_INSTR*INSTR_W-1:0] prog_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [CYC_W-1:0]         total_o,
  output logic [N_INSTR*CYC_W-1:0] start_cyc_o,
  output logic [N_INSTR*CYC_W-1:0] finish_cyc_o
);

  // start-up latency of the unit an opcode runs on
  function automatic logic [CYC_W-1:0] lat_of(input logic [2:0] op);
    if (op_is_mem(op))      return CYC_W'(LAT_LS);
    else if (op_is_mul(op)) return CYC_W'(LAT_MUL);
    else if (op == OP_ADDV) return CYC_W'(LAT_ADD);
    else                    return '0;
  endfunction

  // cycles from start to last element
  function automatic logic [CYC_W-1:0] span_of(input logic [2:0] op);
    return op_valid(op) ? lat_of(op) + CYC_W'(VLEN) : '0;
  endfunction

  run_state_e              state_q;
  logic [N_INSTR*INSTR_W-1:0] prog_q;
  logic [CNT_W-1:0]        nlim_q, idx_q, n_eff;
  logic                    chain_q;
  logic [1:0]              mode_q;
  logic [CYC_W-1:0]        prev_start_q, total_q;
  logic [CYC_W-1:0]        st_q [N_INSTR];
  logic [CYC_W-1:0]        fn_q [N_INSTR];

  // named internal events
  logic                    accept, commit, last_instr;
  logic [INSTR_W-1:0]      cur;
  logic [2:0]              cur_op;
  logic [REG_W-1:0]        cur_dst, cur_a, cur_b;
  logic [CYC_W-1:0]        chain_start, cur_start, cur_fin, cur_first;
  logic                    slot_ok, conv_need_new, conv_dep;
  logic [CYC_W-1:0]        slot_free, conv_base;
  logic [CYC_W-1:0]        first_a, first_b;
  logic                    inconv_a, inconv_b;

  assign n_eff      = (n_instr_i > CNT_W'(N_INSTR)) ? CNT_W'(N_INSTR) : n_instr_i;
  assign accept     = start_i && (state_q != ST_RUN);
  assign commit     = (state_q == ST_RUN);
  assign last_instr = (idx_q == nlim_q - CNT_W'(1));

  always_comb begin
    cur = '0;
    for (int i = 0; i < N_INSTR; i++)
      if (idx_q == CNT_W'(i)) cur = prog_q[i*INSTR_W +: INSTR_W];
  end

  assign cur_op  = cur[INSTR_W-1 -: 3];
  assign cur_dst = cur[3*REG_W-1 -: REG_W];
  assign cur_a   = cur[2*REG_W-1 -: REG_W];
  assign cur_b   = cur[REG_W-1:0];

  assign conv_dep = (op_reads_a(cur_op) && inconv_a) || (op_reads_b(cur_op) && inconv_b);

  vchain_units #(.CYC_W(CYC_W)) u_units (
    .clk(clk), .rst_n(rst_n), .clr(accept), .commit(commit),
    .op(cur_op), .ls_mode(mode_q), .fin(cur_fin),
    .slot_ok(slot_ok), .slot_free(slot_free)
  );

  vchain_regs #(.NREG(N_VREG), .REG_W(REG_W), .CYC_W(CYC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .rd_a(cur_a), .rd_b(cur_b),
    .wr_en(commit && op_writes(cur_op)), .wr_addr(cur_dst), .wr_first(cur_first),
    .conv_clear(commit && conv_need_new),
    .first_a(first_a), .first_b(first_b), .inconv_a(inconv_a), .inconv_b(inconv_b)
  );

  vchain_convoy #(.CYC_W(CYC_W)) u_convoy (
    .clk(clk), .rst_n(rst_n), .clr(accept), .commit(commit),
    .op(cur_op), .ls_mode(mode_q), .dep_hit(conv_dep), .fin(cur_fin),
    .need_new(conv_need_new), .base(conv_base)
  );

  // chained issue: latest of program order, unit release, first source elements
  always_comb begin
    chain_start = prev_start_q;
    if (slot_ok && slot_free > chain_start) chain_start = slot_free;
    if (op_reads_a(cur_op) && first_a > chain_start) chain_start = first_a;
    if (op_reads_b(cur_op) && first_b > chain_start) chain_start = first_b;
  end

  assign cur_start = chain_q ? chain_start : conv_base;
  assign cur_fin   = cur_start + span_of(cur_op);
  assign cur_first = cur_start + lat_of(cur_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; prog_q <= '0; nlim_q <= '0; idx_q <= '0;
      chain_q <= 1'b0; mode_q <= '0; prev_start_q <= '0; total_q <= '0;
      for (int i = 0; i < N_INSTR; i++) begin st_q[i] <= '0; fn_q[i] <= '0; end
    end else if (accept) begin
      prog_q <= prog_i; nlim_q <= n_eff; idx_q <= '0;
      chain_q <= chain_en_i; mode_q <= ls_mode_i;
      prev_start_q <= '0; total_q <= '0;
      for (int i = 0; i < N_INSTR; i++) begin st_q[i] <= '0; fn_q[i] <= '0; end
      state_q <= (n_eff == '0) ? ST_DONE : ST_RUN;
    end else if (commit) begin
      for (int i = 0; i < N_INSTR; i++) begin
        if (idx_q == CNT_W'(i)) begin st_q[i] <= cur_start; fn_q[i] <= cur_fin; end
      end
      idx_q        <= idx_q + CNT_W'(1);
      prev_start_q <= cur_start;
      if (cur_fin > total_q) total_q <= cur_fin;
      if (last_instr) state_q <= ST_DONE;
    end
  end

  for (genvar g = 0; g < N_INSTR; g++) begin : g_out
    assign start_cyc_o[g*CYC_W +: CYC_W]  = st_q[g];
    assign finish_cyc_o[g*CYC_W +: CYC_W] = fn_q[g];
  end

  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
  assign total_o = total_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R2

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(total_o)); // R2

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cur_start >= prev_start_q); // R4

  AST_CHAIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    commit && chain_q && op_reads_a(cur_op) |-> cur_start >= first_a); // R5

  AST_UNIT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit && chain_q && slot_ok |-> cur_start >= slot_free); // R6

  AST_CONVOY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !chain_q && op_reads_a(cur_op) && inconv_a
    |-> cur_start >= first_a + CYC_W'(VLEN)); // R8

endmodule

// File: tb/tb_vchain_seq.sv
`timescale 1ns/1ps
module tb_vchain_seq;

  localparam int N  = 8;
  localparam int CW = 12;
  localparam int IW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          chain_en_i = 1'b0;
  logic [1:0]    ls_mode_i = 2'd0;
  logic [3:0]    n_instr_i = 4'd0;
  logic [N*IW-1:0] prog_i = '0;
  logic          busy_o, done_o;
  logic [CW-1:0] total_o;
  logic [N*CW-1:0] start_cyc_o, finish_cyc_o;

  vchain_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_en_i(chain_en_i),
    .ls_mode_i(ls_mode_i), .n_instr_i(n_instr_i), .prog_i(prog_i),
    .busy_o(busy_o), .done_o(done_o), .total_o(total_o),
    .start_cyc_o(start_cyc_o), .finish_cyc_o(finish_cyc_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int p_op[N], p_d[N], p_a[N], p_b[N];
  int e_s[N], e_f[N], e_tot;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic clear_prog();
    for (int i = 0; i < N; i++) begin p_op[i] = 6; p_d[i] = 0; p_a[i] = 0; p_b[i] = 0; end
  endtask

  task automatic put(input int i, input int op, input int d, input int a, input int b);
    p_op[i] = op; p_d[i] = d; p_a[i] = a; p_b[i] = b;
  endtask

  function automatic logic [N*IW-1:0] pack_prog();
    logic [N*IW-1:0] v = '0;
    for (int i = 0; i < N; i++)
      v[i*IW +: IW] = {3'(p_op[i]), 3'(p_d[i]), 3'(p_a[i]), 3'(p_b[i])};
    return v;
  endfunction

  function automatic int latency(input int op);
    case (op)
      0, 1:    return 12;
      2, 3:    return 7;
      4:       return 6;
      default: return -1;
    endcase
  endfunction

  // schedule derived from the requirements
  task automatic model(input bit ch, input int md, input int n);
    int uf[4]; int rf[8]; bit inc[8];
    int prev, cs, ce, c_ls, c_ld, c_st, c_mul, c_add;
    prev = 0; cs = 0; ce = 0; c_ls = 0; c_ld = 0; c_st = 0; c_mul = 0; c_add = 0;
    for (int k = 0; k < 4; k++) uf[k] = 0;
    for (int k = 0; k < 8; k++) begin rf[k] = 0; inc[k] = 0; end
    e_tot = 0;
    for (int i = 0; i < n; i++) begin
      int op, lt, s, f, u;
      bit ra, rb, wr, mem, full, dep;
      op = p_op[i]; lt = latency(op);
      mem = (op == 0 || op == 1);
      ra = (op >= 1 && op <= 4); rb = (op == 2 || op == 4); wr = (op == 0 || (op >= 2 && op <= 4));
      if (lt < 0) u = -1;
      else if (op == 2 || op == 3) u = 2;
      else if (op == 4) u = 3;
      else if (md == 1) u = (op == 0) ? 0 : 1;
      else if (md == 2) u = (uf[1] < uf[0]) ? 1 : 0;
      else u = 0;
      if (ch) begin
        s = prev;
        if (u >= 0 && uf[u] > s) s = uf[u];
        if (ra && rf[p_a[i]] > s) s = rf[p_a[i]];
        if (rb && rf[p_b[i]] > s) s = rf[p_b[i]];
      end else begin
        if (mem) full = (md == 1) ? ((op == 0) ? (c_ld > 0) : (c_st > 0))
                                  : ((md == 2) ? (c_ls > 1) : (c_ls > 0));
        else if (op == 2 || op == 3) full = (c_mul > 0);
        else if (op == 4) full = (c_add > 0);
        else full = 0;
        dep = (ra && inc[p_a[i]]) || (rb && inc[p_b[i]]);
        if (lt >= 0 && (dep || full)) begin
          cs = ce; c_ls = 0; c_ld = 0; c_st = 0; c_mul = 0; c_add = 0;
          for (int k = 0; k < 8; k++) inc[k] = 0;
        end
        s = cs;
      end
      f = (lt < 0) ? s : s + lt + 64;
      if (lt >= 0) begin
        if (u >= 0) uf[u] = f;
        if (wr) begin rf[p_d[i]] = s + lt; inc[p_d[i]] = 1; end
        if (mem) c_ls++;
        if (op == 0) c_ld++;
        if (op == 1) c_st++;
        if (op == 2 || op == 3) c_mul++;
        if (op == 4) c_add++;
        if (f > ce) ce = f;
      end
      prev = s; e_s[i] = s; e_f[i] = f;
      if (f > e_tot) e_tot = f;
    end
  endtask

  function automatic int got_s(input int i);
    return int'(start_cyc_o[i*CW +: CW]);
  endfunction

  function automatic int got_f(input int i);
    return int'(finish_cyc_o[i*CW +: CW]);
  endfunction

  // start a program, check the done latency, then the whole schedule
  task automatic run_prog(input bit ch, input int md, input int n, input bit inject, input string tag);
    int lat, neff;
    logic [N*IW-1:0] pv;
    pv = pack_prog();
    neff = (n > N) ? N : n;
    @(negedge clk);
    chain_en_i = ch; ls_mode_i = 2'(md); n_instr_i = 4'(n); prog_i = pv; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    if (neff > 0) check("R2", "busy after start", int'(busy_o), 1);
    if (inject && busy_o) begin
      start_i = 1'b1; prog_i = '0; chain_en_i = ~ch; ls_mode_i = 2'd2; n_instr_i = 4'd1;
      @(posedge clk); lat++;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && lat < 1000) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    check("R2", "done latency", lat, neff);
    check("R2", "busy low at done", int'(busy_o), 0);
    model(ch, md, neff);
    for (int i = 0; i < neff; i++) begin
      check(tag, $sformatf("start[%0d]", i), got_s(i), e_s[i]);
      check(tag, $sformatf("finish[%0d]", i), got_f(i), e_f[i]);
    end
    check("R11", "total", int'(total_o), e_tot);
  endtask

  task automatic t_reset();
    check("R1", "busy", int'(busy_o), 0);
    check("R1", "done", int'(done_o), 0);
    check("R1", "total", int'(total_o), 0);
    check("R1", "start outputs", int'(start_cyc_o == '0), 1);
    check("R1", "finish outputs", int'(finish_cyc_o == '0), 1);
  endtask

  // load, scale, store with chaining on a shared port
  task automatic t_chain_shared();
    clear_prog();
    put(0, 0, 1, 0, 0); put(1, 3, 2, 1, 0); put(2, 1, 0, 2, 0);
    run_prog(1'b1, 0, 3, 1'b0, "R6 R3 R12");
    check("R13", "shared chained total", int'(total_o), 152);
    check("R6", "store waits for port", got_s(2), 76);
    check("R5", "scale starts on first element", got_s(1), 12);
  endtask

  task automatic t_chain_split();
    clear_prog();
    put(0, 0, 1, 0, 0); put(1, 3, 2, 1, 0); put(2, 1, 0, 2, 0);
    run_prog(1'b1, 1, 3, 1'b1, "R5 R3");
    check("R13", "split chained total", int'(total_o), 95);
    check("R2", "start while busy ignored", got_s(2), 19);
  endtask

  task automatic load_mac();
    clear_prog();
    put(0, 0, 5, 0, 0); put(1, 0, 1, 0, 0); put(2, 2, 2, 1, 5);
    put(3, 0, 3, 0, 0); put(4, 4, 4, 2, 3); put(5, 1, 0, 4, 0);
  endtask

  task automatic t_nochain_dual();
    load_mac();
    run_prog(1'b0, 2, 6, 1'b0, "R8");
    check("R13", "unchained multiply-add total", int'(total_o), 298);
    check("R8", "second load joins convoy", got_s(3), 76);
  endtask

  task automatic t_chain_dual();
    load_mac();
    run_prog(1'b1, 2, 6, 1'b0, "R7 R5");
    check("R7", "dual chained total", int'(total_o), 170);
  endtask

  task automatic t_mode3();
    clear_prog();
    put(0, 0, 1, 0, 0); put(1, 3, 2, 1, 0); put(2, 1, 0, 2, 0);
    run_prog(1'b1, 3, 3, 1'b0, "R7");
    check("R7", "mode 3 acts shared", int'(total_o), 152);
  endtask

  task automatic t_ignored_fields();
    clear_prog();
    put(0, 0, 1, 5, 6); put(1, 0, 4, 7, 3); put(2, 3, 2, 1, 4); put(3, 1, 0, 2, 0);
    run_prog(1'b1, 0, 4, 1'b0, "R9");
    check("R9", "scalar field ignored", got_s(2), 76);
    check("R9", "store start", got_s(3), 152);
    check("R9", "total", int'(total_o), 228);
  endtask

  task automatic t_nop();
    clear_prog();
    put(0, 0, 1, 0, 0); put(1, 7, 3, 1, 1); put(2, 3, 2, 1, 0); put(3, 1, 0, 2, 0);
    run_prog(1'b1, 1, 4, 1'b0, "R10");
    check("R10", "nop start", got_s(1), 0);
    check("R10", "nop finish", got_f(1), 0);
    check("R10", "chained total unchanged", int'(total_o), 95);
    clear_prog();
    put(0, 0, 1, 0, 0); put(1, 5, 0, 0, 0); put(2, 4, 2, 1, 1); put(3, 6, 0, 0, 0);
    run_prog(1'b0, 1, 4, 1'b0, "R10 R8");
    check("R10", "nop after add", got_f(3), 76);
  endtask

  task automatic t_in_order();
    clear_prog();
    put(0, 0, 1, 0, 0); put(1, 0, 2, 0, 0); put(2, 4, 3, 4, 5);
    run_prog(1'b1, 0, 3, 1'b0, "R4");
    check("R4", "independent add held in order", got_s(2), 76);
  endtask

  task automatic t_counts();
    clear_prog();
    run_prog(1'b1, 0, 0, 1'b0, "R2");
    check("R11", "empty total", int'(total_o), 0);
    clear_prog();
    for (int i = 0; i < N; i++) put(i, (i % 2 == 0) ? 0 : 4, i, (i + 7) % 8, i);
    run_prog(1'b1, 2, 12, 1'b0, "R2 R6");
    clear_prog();
    for (int i = 0; i < N; i++) put(i, (i % 3 == 0) ? 0 : ((i % 3 == 1) ? 2 : 1), i % 4, (i + 3) % 4, i % 4);
    run_prog(1'b0, 1, 8, 1'b0, "R8 R3");
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_chain_shared();
    t_chain_split();
    t_nochain_dual();
    t_chain_dual();
    t_mode3();
    t_ignored_fields();
    t_nop();
    t_in_order();
    t_counts();
    finish_run();
  end

endmodule